// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox

The block is a register-mapped mailbox shared by a local core and a peer core. It holds 32 one-way slots. Each slot has a control word, which holds a one-hot slot state and a completion-mode bit, and an eight-word message buffer. A sender writes the message words. It then moves the slot to the transmitting state and rings the other core by setting a bit in a doorbell vector. The receiver reads the words. It then writes the acknowledged state into the slot. Depending on the completion mode, the hardware either returns the slot to idle at once or latches an acknowledge interrupt for the local core.

Both cores reach the same storage through identical single-cycle register ports. Byte address bit 12 selects the interrupt-control bank (bit 12 set) or the slot windows (bit 12 clear). Each slot window is 0x40 bytes: slot s starts at s*0x40, its control word is at window offset 0 and message word k (k = 0..7) is at offset 4+4k. Reads return data one clock after the request. The local core receives one combined acknowledge interrupt and the peer receives one combined doorbell interrupt.

Each slot is a four-state machine. Its states are IDLE (code 0x1), TX (0x2), RX (0x4) and ACK (0x8), held in control bits 7:4. The completion-mode bit is bit 0: 1 means automatic return to idle and 0 means the acknowledge interrupt is raised. The transitions are:
- write-idle, write-tx and write-rx move the slot to the written state from any state.
- A peer-ack write in automatic mode goes to IDLE.
- Any other ack write goes to ACK.
- A write whose state code is not one-hot holds the current state.

Top module: `mbox_ipc`

## Requirements
- R1: After reset, every control word reads 0x10 (state IDLE, mode 0), every message word reads 0, all interrupt-bank registers read 0, and both interrupt outputs are low.
- R2: A message word written from either port reads back from either port at window offset 4+4k of its slot, one clock after the read request.
- R3: A control-word write stores bits 7:4 and bit 0 and reads all other bits as zero. A write whose bits 7:4 are not one-hot leaves the state unchanged but still updates bit 0.
- R4: When both ports write the same word in the same cycle, the peer port's data is kept.
- R5: A local write to bank offset 0x420 sets the doorbell bits where the data has ones. A peer write to 0x420 clears the bits where the data has ones. The peer interrupt is high while any doorbell bit is set. When a set and a clear of the same bit come in the same cycle, the set wins.
- R6: A peer write of state 0x8 with bit 0 = 1 leaves the slot reading IDLE (0x1) and leaves the acknowledge raw register (offset 0x400) unchanged.
- R7: A peer write of state 0x8 with bit 0 = 0 leaves the slot reading ACK and sets bit s of the acknowledge raw register, where s is the slot index.
- R8: The status register (0x408) reads raw AND enable. The local interrupt is high exactly while status is nonzero.
- R9: The enable vector reads at 0x404 and is loaded directly by writes there. Ones written to 0x500 set enable bits and ones written to 0x504 clear them. Zero bits written to 0x500 or 0x504 have no effect.
- R10: Ones written to 0x40C clear the matching raw bits and zero bits have no effect. A hardware set in the same cycle as a clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_req | input | 1 | Local port access strobe |
| loc_we | input | 1 | Local port write (1) or read (0) |
| loc_addr | input | 13 | Local port byte address |
| loc_wdata | input | 32 | Local port write data |
| loc_rdata | output | 32 | Local port read data, one clock after the request |
| pr_req | input | 1 | Peer port access strobe |
| pr_we | input | 1 | Peer port write (1) or read (0) |
| pr_addr | input | 13 | Peer port byte address |
| pr_wdata | input | 32 | Peer port write data |
| pr_rdata | output | 32 | Peer port read data, one clock after the request |
| loc_irq | output | 1 | Combined acknowledge interrupt to the local core |
| peer_irq | output | 1 | Combined doorbell interrupt to the peer core |

## Verification
The hardest cases to reach from the ports are same-cycle collisions between the two cores. Examples are a hardware acknowledge set landing on the same raw bit that software is clearing, and both ports writing one message word or control word together. A single sequential access stream never produces these. The bench therefore has a task that presents a local access and a peer access in the same clock. It uses that task for a peer ack-state write racing a local clear of the same raw bit, and for same-address data and control writes. It then reads the results back and checks the interrupt line.

// File: rtl/mbox_ipc_pkg.sv
package mbox_ipc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'b0001,
        ST_TX   = 4'b0010,
        ST_RX   = 4'b0100,
        ST_ACK  = 4'b1000
    } slot_state_e;

    localparam int          OFF_W        = 12;
    localparam logic [11:0] OFF_ACK_RAW  = 12'h400;
    localparam logic [11:0] OFF_ACK_MASK = 12'h404;
    localparam logic [11:0] OFF_ACK_STAT = 12'h408;
    localparam logic [11:0] OFF_ACK_CLR  = 12'h40C;
    localparam logic [11:0] OFF_DST_RAW  = 12'h420;
    localparam logic [11:0] OFF_ACK_ENA  = 12'h500;
    localparam logic [11:0] OFF_ACK_DIS  = 12'h504;

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_ipc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_peer,
    input  logic [3:0]  wr_state,
    input  logic        wr_auto,
    output slot_state_e state_q,
    output logic        auto_q,
    output logic        ack_evt
);

    slot_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (wr_state)
                ST_IDLE, ST_TX, ST_RX: state_d = slot_state_e'(wr_state);
                ST_ACK:                state_d = (wr_peer && wr_auto) ? ST_IDLE : ST_ACK;
                default:               state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            auto_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_en) auto_q <= wr_auto;
        end
    end

    // completion event toward the interrupt bank
    always_comb begin
        ack_evt = wr_en && wr_peer && (wr_state == ST_ACK) && !wr_auto;
    end

    // R6
    auto_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_peer && wr_state == 4'h8 && wr_auto) |=> (state_q == ST_IDLE));

    // R3
    bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $countones(wr_state) != 1) |=> $stable(state_q));

endmodule

// File: rtl/mbox_irq_bank.sv
module mbox_irq_bank
    import mbox_ipc_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_wr,
    input  logic [OFF_W-1:0] loc_off,
    input  logic [NVEC-1:0]  loc_wd,
    input  logic             pr_wr,
    input  logic [OFF_W-1:0] pr_off,
    input  logic [NVEC-1:0]  pr_wd,
    input  logic [NVEC-1:0]  ack_set,
    output logic [NVEC-1:0]  raw_q,
    output logic [NVEC-1:0]  en_q,
    output logic [NVEC-1:0]  dst_q,
    output logic             loc_irq,
    output logic             peer_irq
);

    logic [NVEC-1:0] en_d, raw_d, dst_d, ack_clr, dst_set, dst_clr;

    always_comb begin
        en_d = en_q;
        if (loc_wr) begin
            unique case (loc_off)
                OFF_ACK_MASK: en_d = loc_wd;
                OFF_ACK_ENA:  en_d = en_d | loc_wd;
                OFF_ACK_DIS:  en_d = en_d & ~loc_wd;
                default:      en_d = en_d;
            endcase
        end
        if (pr_wr) begin
            unique case (pr_off)
                OFF_ACK_MASK: en_d = pr_wd;
                OFF_ACK_ENA:  en_d = en_d | pr_wd;
                OFF_ACK_DIS:  en_d = en_d & ~pr_wd;
                default:      en_d = en_d;
            endcase
        end
        ack_clr = ((loc_wr && loc_off == OFF_ACK_CLR) ? loc_wd : '0)
                | ((pr_wr && pr_off == OFF_ACK_CLR) ? pr_wd : '0);
        dst_set = (loc_wr && loc_off == OFF_DST_RAW) ? loc_wd : '0;
        dst_clr = (pr_wr && pr_off == OFF_DST_RAW) ? pr_wd : '0;
        raw_d   = (raw_q & ~ack_clr) | ack_set;
        dst_d   = (dst_q & ~dst_clr) | dst_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            raw_q <= '0;
            dst_q <= '0;
        end else begin
            en_q  <= en_d;
            raw_q <= raw_d;
            dst_q <= dst_d;
        end
    end

    always_comb begin
        loc_irq  = |(raw_q & en_q);
        peer_irq = |dst_q;
    end

    // R10
    raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_clr & ~ack_set)) |=> ((raw_q & $past(ack_clr & ~ack_set)) == '0));

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ack_set & en_q)) && !loc_wr && !pr_wr) |=> loc_irq);

    // R5
    bell_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dst_set) |=> peer_irq);

endmodule

// File: rtl/mbox_ipc.sv
module mbox_ipc
    import mbox_ipc_pkg::*;
#(
    parameter int NSLOT     = 32,
    parameter int MSG_WORDS = 8,
    parameter int DW        = 32,
    parameter int AW        = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loc_req,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [DW-1:0] loc_wdata,
    output logic [DW-1:0] loc_rdata,
    input  logic          pr_req,
    input  logic          pr_we,
    input  logic [AW-1:0] pr_addr,
    input  logic [DW-1:0] pr_wdata,
    output logic [DW-1:0] pr_rdata,
    output logic          loc_irq,
    output logic          peer_irq
);

    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int WIX_W   = $clog2(MSG_WORDS);
    localparam int WIN_LSB = 6;
    localparam int SLOT_HI = WIN_LSB + SLOT_W;

    // port 0 = local, port 1 = peer
    logic              p_req [2];
    logic              p_we  [2];
    logic [AW-1:0]     p_addr[2];
    logic [DW-1:0]     p_wd  [2];
    logic [DW-1:0]     p_rd  [2];
    logic              is_ipc[2], is_mode[2], is_data[2];
    logic [SLOT_W-1:0] p_slot[2];
    logic [3:0]        p_word[2];
    logic [WIX_W-1:0]  p_wix [2];

    assign p_req[0] = loc_req;  assign p_we[0] = loc_we;
    assign p_addr[0] = loc_addr; assign p_wd[0] = loc_wdata;
    assign p_req[1] = pr_req;   assign p_we[1] = pr_we;
    assign p_addr[1] = pr_addr;  assign p_wd[1] = pr_wdata;
    assign loc_rdata = p_rd[0];
    assign pr_rdata  = p_rd[1];

    for (genvar i = 0; i < 2; i++) begin : g_dec
        logic win_ok;
        always_comb begin
            is_ipc[i]  = p_addr[i][AW-1];
            win_ok     = !p_addr[i][AW-1] && (p_addr[i][AW-2:SLOT_HI] == '0)
                         && (p_addr[i][1:0] == 2'b00);
            p_slot[i]  = p_addr[i][SLOT_HI-1:WIN_LSB];
            p_word[i]  = p_addr[i][5:2];
            p_wix[i]   = WIX_W'(p_word[i] - 4'd1);
            is_mode[i] = win_ok && (p_word[i] == 4'd0);
            is_data[i] = win_ok && (p_word[i] != 4'd0) && (32'(p_word[i]) <= MSG_WORDS);
        end
    end

    // slot control words
    slot_state_e     slot_state[NSLOT];
    logic [NSLOT-1:0] slot_auto, ack_set;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic l_hit, r_hit;
        assign l_hit = p_req[0] && p_we[0] && is_mode[0] && (p_slot[0] == SLOT_W'(s));
        assign r_hit = p_req[1] && p_we[1] && is_mode[1] && (p_slot[1] == SLOT_W'(s));
        mbox_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (l_hit || r_hit),
            .wr_peer  (r_hit),
            .wr_state (r_hit ? p_wd[1][7:4] : p_wd[0][7:4]),
            .wr_auto  (r_hit ? p_wd[1][0] : p_wd[0][0]),
            .state_q  (slot_state[s]),
            .auto_q   (slot_auto[s]),
            .ack_evt  (ack_set[s])
        );
    end

    // interrupt bank
    logic [NSLOT-1:0] raw_q, en_q, dst_q;

    mbox_irq_bank #(.NVEC(NSLOT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .loc_wr   (p_req[0] && p_we[0] && is_ipc[0]),
        .loc_off  (p_addr[0][OFF_W-1:0]),
        .loc_wd   (p_wd[0][NSLOT-1:0]),
        .pr_wr    (p_req[1] && p_we[1] && is_ipc[1]),
        .pr_off   (p_addr[1][OFF_W-1:0]),
        .pr_wd    (p_wd[1][NSLOT-1:0]),
        .ack_set  (ack_set),
        .raw_q    (raw_q),
        .en_q     (en_q),
        .dst_q    (dst_q),
        .loc_irq  (loc_irq),
        .peer_irq (peer_irq)
    );

    // message storage; peer write applied last so it wins
    logic [DW-1:0] mem [NSLOT][MSG_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++)
                for (int w = 0; w < MSG_WORDS; w++)
                    mem[s][w] <= '0;
        end else begin
            for (int i = 0; i < 2; i++)
                if (p_req[i] && p_we[i] && is_data[i])
                    mem[p_slot[i]][p_wix[i]] <= p_wd[i];
        end
    end

    // registered read path
    for (genvar i = 0; i < 2; i++) begin : g_rd
        logic [DW-1:0] rd_d;
        always_comb begin
            rd_d = '0;
            if (is_ipc[i]) begin
                unique case (p_addr[i][OFF_W-1:0])
                    OFF_ACK_RAW:  rd_d = DW'(raw_q);
                    OFF_ACK_MASK: rd_d = DW'(en_q);
                    OFF_ACK_STAT: rd_d = DW'(raw_q & en_q);
                    OFF_DST_RAW:  rd_d = DW'(dst_q);
                    default:      rd_d = '0;
                endcase
            end else if (is_mode[i]) begin
                rd_d = DW'({slot_state[p_slot[i]], 3'b000, slot_auto[p_slot[i]]});
            end else if (is_data[i]) begin
                rd_d = mem[p_slot[i]][p_wix[i]];
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n)                   p_rd[i] <= '0;
            else if (p_req[i] && !p_we[i]) p_rd[i] <= rd_d;
        end
    end

endmodule

// File: tb/mbox_ipc_bench.sv
module mbox_ipc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_req = 0, loc_we = 0, pr_req = 0, pr_we = 0;
    logic [12:0] loc_addr = '0, pr_addr = '0;
    logic [31:0] loc_wdata = '0, pr_wdata = '0;
    logic [31:0] loc_rdata, pr_rdata;
    logic        loc_irq, peer_irq;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    mbox_ipc u_mbox_ipc (
        .clk(clk), .rst_n(rst_n),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .pr_req(pr_req), .pr_we(pr_we), .pr_addr(pr_addr),
        .pr_wdata(pr_wdata), .pr_rdata(pr_rdata),
        .loc_irq(loc_irq), .peer_irq(peer_irq)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        port;
        logic        we;
        logic [12:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{8'd2,  1'b0, 1'b1, 13'h00C4, 32'hA5A50001, 32'h0},        // R2 local data
        '{8'd2,  1'b0, 1'b0, 13'h00C4, 32'h0,        32'hA5A50001}, // R2
        '{8'd2,  1'b1, 1'b1, 13'h07E0, 32'h12345678, 32'h0},        // R2 peer, last word
        '{8'd2,  1'b0, 1'b0, 13'h07E0, 32'h0,        32'h12345678}, // R2
        '{8'd3,  1'b0, 1'b1, 13'h0140, 32'hFFFFFF21, 32'h0},        // R3 tx + auto
        '{8'd3,  1'b1, 1'b0, 13'h0140, 32'h0,        32'h00000021}, // R3
        '{8'd3,  1'b0, 1'b1, 13'h0140, 32'h00000030, 32'h0},        // R3 bad code
        '{8'd3,  1'b0, 1'b0, 13'h0140, 32'h0,        32'h00000020}, // R3
        '{8'd6,  1'b1, 1'b1, 13'h0140, 32'h00000081, 32'h0},        // R6 auto ack
        '{8'd6,  1'b0, 1'b0, 13'h0140, 32'h0,        32'h00000011}, // R6
        '{8'd6,  1'b0, 1'b0, 13'h1400, 32'h0,        32'h0},        // R6 raw untouched
        '{8'd9,  1'b0, 1'b1, 13'h1500, 32'h00000080, 32'h0},        // R9 enable bit 7
        '{8'd7,  1'b1, 1'b1, 13'h01C0, 32'h00000080, 32'h0},        // R7 irq-mode ack
        '{8'd7,  1'b0, 1'b0, 13'h01C0, 32'h0,        32'h00000080}, // R7
        '{8'd7,  1'b0, 1'b0, 13'h1400, 32'h0,        32'h00000080}, // R7
        '{8'd8,  1'b0, 1'b0, 13'h1408, 32'h0,        32'h00000080}  // R8
    };

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_ports();
        loc_req = 0; loc_we = 0; pr_req = 0; pr_we = 0;
    endtask

    task automatic wr(input logic port, input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        if (!port) begin loc_req = 1; loc_we = 1; loc_addr = a; loc_wdata = d; end
        else       begin pr_req = 1;  pr_we = 1;  pr_addr = a;  pr_wdata = d;  end
        @(negedge clk);
        idle_ports();
    endtask

    task automatic wr2(input logic [12:0] la, input logic [31:0] ld,
                       input logic [12:0] pa, input logic [31:0] pd);
        @(negedge clk);
        loc_req = 1; loc_we = 1; loc_addr = la; loc_wdata = ld;
        pr_req = 1;  pr_we = 1;  pr_addr = pa;  pr_wdata = pd;
        @(negedge clk);
        idle_ports();
    endtask

    task automatic rd(input logic port, input logic [12:0] a, input logic [31:0] exp,
                      input string tag);
        @(negedge clk);
        if (!port) begin loc_req = 1; loc_we = 0; loc_addr = a; end
        else       begin pr_req = 1;  pr_we = 0;  pr_addr = a;  end
        @(negedge clk);
        idle_ports();
        check(port ? pr_rdata : loc_rdata, exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, 13'h0000, 32'h10, "R1 slot0 ctrl");
        rd(1, 13'h07C0, 32'h10, "R1 slot31 ctrl");
        rd(0, 13'h0004, 32'h0,  "R1 data");
        rd(0, 13'h1400, 32'h0,  "R1 raw");
        rd(1, 13'h1420, 32'h0,  "R1 doorbell");
        check({31'b0, loc_irq},  32'h0, "R1 loc_irq");
        check({31'b0, peer_irq}, 32'h0, "R1 peer_irq");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) wr(VEC[i].port, VEC[i].addr, VEC[i].wd);
            else rd(VEC[i].port, VEC[i].addr, VEC[i].exp, $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        check({31'b0, loc_irq}, 32'h1, "R8 irq on status");
        // R9 zero writes are no-ops
        wr(0, 13'h1504, 32'h0);
        check({31'b0, loc_irq}, 32'h1, "R9 disable zero");
        wr(0, 13'h1500, 32'h0);
        rd(0, 13'h1404, 32'h80, "R9 enable zero");
        wr(0, 13'h1504, 32'h80);
        check({31'b0, loc_irq}, 32'h0, "R9 disabled irq");
        rd(0, 13'h1408, 32'h0,  "R8 masked status");
        rd(0, 13'h1400, 32'h80, "R8 raw kept");
        wr(0, 13'h1404, 32'h0000F0F0);
        rd(1, 13'h1404, 32'h0000F0F0, "R9 direct mask");
        rd(0, 13'h1408, 32'h80, "R8 status");
        check({31'b0, loc_irq}, 32'h1, "R8 irq again");
        // R10 clear
        wr(0, 13'h140C, 32'h0);
        rd(0, 13'h1400, 32'h80, "R10 zero clear");
        wr(1, 13'h140C, 32'h80);
        rd(0, 13'h1400, 32'h0, "R10 clear");
        check({31'b0, loc_irq}, 32'h0, "R10 irq drop");
        // R10 set beats clear: peer acks slot 9 while local clears bit 9
        wr2(13'h140C, 32'h200, 13'h0240, 32'h80);
        rd(0, 13'h1400, 32'h200, "R10 set wins");
        rd(1, 13'h0240, 32'h80,  "R7 slot9 ack");
        check({31'b0, loc_irq}, 32'h0, "R8 unenabled bit");
        // R5 doorbell
        wr(0, 13'h1420, 32'h5);
        check({31'b0, peer_irq}, 32'h1, "R5 ring");
        rd(1, 13'h1420, 32'h5, "R5 bits");
        wr(1, 13'h1420, 32'h4);
        rd(0, 13'h1420, 32'h1, "R5 partial clear");
        check({31'b0, peer_irq}, 32'h1, "R5 still set");
        wr(1, 13'h1420, 32'h1);
        check({31'b0, peer_irq}, 32'h0, "R5 cleared");
        wr2(13'h1420, 32'h8, 13'h1420, 32'h8);
        rd(0, 13'h1420, 32'h8, "R5 set wins");
        // R4 collisions
        wr2(13'h00C4, 32'h11111111, 13'h00C4, 32'h22222222);
        rd(0, 13'h00C4, 32'h22222222, "R4 data");
        wr2(13'h0300, 32'h21, 13'h0300, 32'h40);
        rd(0, 13'h0300, 32'h40, "R4 ctrl");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule